// File: doc/BRIEF.md
# Synchronous Framed Serial Transmitter

This block sends frames over a synchronous serial link. It drives the bit clock on its own output beside the data line, so the far end needs no clock recovery. A processor-side path pushes data bytes into an eight-entry transmit buffer. A separate write loads a configuration register that holds the sync pattern, the number of data bytes per frame and a switch that turns the CRC trailer on or off.

A start pulse begins a frame when the block is idle and the buffer already holds a full frame of bytes. The frame has three parts, in order: the sync byte, the data bytes taken from the buffer, and an optional 16-bit CRC over the data bytes only. Each bit goes out on one pulse of the `bit_en` input. Between frames both lines rest high. Because the buffer has eight entries, a block of bytes for several frames can be loaded ahead of time. Each start then takes the next bytes in order.

Top module: `sync_frame_tx`

## Requirements
- R1: After reset and between frames, `ser_data` and `ser_clk` are both 1 and `busy` is 0. After reset, `wr_ovf` is 0.
- R2: A frame sends the sync byte first and then `cfg_len`+1 data bytes (3-bit field: 0 means 1 byte, 7 means 8 bytes). Every byte goes out MSB first, one bit for each `bit_en` pulse.
- R3: When `cfg_crc_en` is 1, a 16-bit CRC follows the data, sent MSB first. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), is seeded with 0xFFFF, and covers the data bits only, not the sync byte.
- R4: When `cfg_crc_en` is 0, the frame ends after the last data bit and holds exactly 8+8*(`cfg_len`+1) bits.
- R5: Each bit is driven in the clock edge that consumes a `bit_en` pulse. At that edge `ser_clk` goes low, and it goes high again one clock cycle later; the receiver samples on that rising edge. `ser_data` changes only when `ser_clk` falls, or when it returns to 1 at the end of a frame.
- R6: `busy` rises in the cycle after an accepted start. It stays high until the `bit_en` pulse that follows the last bit of the frame. A frame therefore consumes exactly (frame bits + 1) `bit_en` pulses while `busy` is high.
- R7: A start pulse is accepted only when the block is idle and the buffer holds at least `cfg_len`+1 bytes. Otherwise the start is ignored and the line stays idle.
- R8: The buffer holds up to 8 bytes in first-in first-out order. Consecutive frames take consecutive bytes, so several frames can be loaded before the first start.
- R9: A write while the buffer holds 8 bytes is dropped and sets `wr_ovf`. The `wr_ovf` flag stays set until reset.
- R10: Sync, length and CRC switch are captured at the accepted start. A configuration write during a frame does not change that frame; it applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-rate enable pulse; one bit per pulse |
| wr_en | input | 1 | Push `wr_data` into the transmit buffer |
| wr_data | input | 8 | Data byte to buffer |
| cfg_we | input | 1 | Load the configuration register |
| cfg_sync | input | 8 | Sync pattern sent at the head of each frame |
| cfg_len | input | 3 | Data bytes per frame minus one |
| cfg_crc_en | input | 1 | 1 appends the CRC trailer |
| start | input | 1 | Request to send one frame |
| ser_clk | output | 1 | Serial bit clock, idle high |
| ser_data | output | 1 | Serial data, idle high |
| busy | output | 1 | A frame is in progress |
| wr_ovf | output | 1 | Sticky flag: a write hit a full buffer |

## Verification
The clocking properties rely on `bit_en` never being high in two consecutive cycles. With that spacing, the low half of `ser_clk` always ends before the next bit is driven. The stimulus generator keeps at least one idle cycle after every pulse and draws the remaining gap from a seeded random source. It also never writes the configuration register in the same cycle as a start, and it issues starts only when its own model of the buffer holds enough bytes, except in the directed cases that check a start is ignored.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_CRC,
    ST_TAIL
  } tx_state_e;

  // one serial step of the CRC shift register, MSB-first input
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sft_fifo.sv
`timescale 1ns/1ps
module sft_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    wp_d  = push_ok ? ptr_inc(wp_q) : wp_q;
    rp_d  = pop_ok  ? ptr_inc(rp_q) : rp_q;
    ovf_d = ovf_q | (push && full);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // storage needs no reset: an entry is read only after it was written
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/sft_crc16.sv
`timescale 1ns/1ps
module sft_crc16 import sft_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_nxt
);
  logic [CRC_W-1:0] crc_q, crc_d;

  assign crc_nxt = crc_step(crc_q, bit_in);

  always_comb begin
    crc_d = crc_q;
    if (clr)      crc_d = CRC_SEED;
    else if (adv) crc_d = crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/sft_tx_ctrl.sv
`timescale 1ns/1ps
module sft_tx_ctrl import sft_pkg::*; #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SHW  = CRC_W,
  localparam int BCW  = $clog2(SHW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start,
  input  logic [W-1:0]     cfg_sync,
  input  logic [LW-1:0]    cfg_len,
  input  logic             cfg_crc_en,
  input  logic [CW-1:0]    fifo_count,
  input  logic [W-1:0]     fifo_head,
  output logic             fifo_pop,
  output logic             crc_clr,
  output logic             crc_adv,
  output logic             crc_bit,
  input  logic [CRC_W-1:0] crc_nxt,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             busy
);
  tx_state_e      st_q, st_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [LW-1:0]  left_q, left_d, len_q, len_d;
  logic           crcen_q, crcen_d;
  logic [SHW-1:0] sh_q, sh_d;
  logic           sdat_q, sdat_d, sclk_q, sclk_d;
  logic           accept;

  assign accept  = (st_q == ST_IDLE) && start && (fifo_count > CW'(cfg_len));
  assign crc_bit = sh_q[SHW-1];

  always_comb begin
    st_d     = st_q;
    bcnt_d   = bcnt_q;
    left_d   = left_q;
    len_d    = len_q;
    crcen_d  = crcen_q;
    sh_d     = sh_q;
    sdat_d   = sdat_q;
    sclk_d   = 1'b1;
    fifo_pop = 1'b0;
    crc_clr  = 1'b0;
    crc_adv  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        sdat_d = 1'b1;
        if (accept) begin
          st_d    = ST_SYNC;
          sh_d    = SHW'(cfg_sync) << (SHW - W);
          bcnt_d  = BCW'(W - 1);
          len_d   = cfg_len;
          crcen_d = cfg_crc_en;
          crc_clr = 1'b1;
        end
      end
      ST_TAIL: begin
        if (bit_en) begin
          sdat_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: begin
        if (bit_en) begin
          sdat_d = sh_q[SHW-1];
          sclk_d = 1'b0;
          sh_d   = {sh_q[SHW-2:0], 1'b0};
          bcnt_d = bcnt_q - BCW'(1);
          crc_adv = (st_q == ST_DATA);
          if (bcnt_q == '0) begin
            if (st_q == ST_SYNC) begin
              st_d     = ST_DATA;
              left_d   = len_q;
              fifo_pop = 1'b1;
              sh_d     = SHW'(fifo_head) << (SHW - W);
              bcnt_d   = BCW'(W - 1);
            end else if (st_q == ST_DATA) begin
              if (left_q != '0) begin
                left_d   = left_q - LW'(1);
                fifo_pop = 1'b1;
                sh_d     = SHW'(fifo_head) << (SHW - W);
                bcnt_d   = BCW'(W - 1);
              end else if (crcen_q) begin
                st_d   = ST_CRC;
                sh_d   = crc_nxt;
                bcnt_d = BCW'(CRC_W - 1);
              end else begin
                st_d = ST_TAIL;
              end
            end else begin
              st_d = ST_TAIL;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bcnt_q  <= '0;
      left_q  <= '0;
      len_q   <= '0;
      crcen_q <= 1'b0;
      sh_q    <= '0;
      sdat_q  <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      st_q    <= st_d;
      bcnt_q  <= bcnt_d;
      left_q  <= left_d;
      len_q   <= len_d;
      crcen_q <= crcen_d;
      sh_q    <= sh_d;
      sdat_q  <= sdat_d;
      sclk_q  <= sclk_d;
    end
  end

  assign ser_clk  = sclk_q;
  assign ser_data = sdat_q;
  assign busy     = (st_q != ST_IDLE);
endmodule

// File: rtl/sync_frame_tx.sv
`timescale 1ns/1ps
module sync_frame_tx import sft_pkg::*; #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          cfg_we,
  input  logic [W-1:0]  cfg_sync,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_crc_en,
  input  logic          start,
  output logic          ser_clk,
  output logic          ser_data,
  output logic          busy,
  output logic          wr_ovf
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [W-1:0]     sync_q, sync_d;
  logic [LW-1:0]    len_q, len_d;
  logic             crcen_q, crcen_d;
  logic [CW-1:0]    fifo_count;
  logic [W-1:0]     fifo_head;
  logic             fifo_pop, crc_clr, crc_adv, crc_bit;
  logic [CRC_W-1:0] crc_nxt;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  always_comb begin
    sync_d  = sync_q;
    len_d   = len_q;
    crcen_d = crcen_q;
    if (cfg_we) begin
      sync_d  = cfg_sync;
      len_d   = cfg_len;
      crcen_d = cfg_crc_en;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sync_q  <= '0;
      len_q   <= '0;
      crcen_q <= 1'b1;
    end else begin
      sync_q  <= sync_d;
      len_q   <= len_d;
      crcen_q <= crcen_d;
    end
  end

  sft_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push      (wr_en),
    .push_data (wr_data),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .count     (fifo_count),
    .ovf       (wr_ovf)
  );

  sft_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (crc_clr),
    .adv     (crc_adv),
    .bit_in  (crc_bit),
    .crc_nxt (crc_nxt)
  );

  sft_tx_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .bit_en     (bit_en),
    .start      (start),
    .cfg_sync   (sync_q),
    .cfg_len    (len_q),
    .cfg_crc_en (crcen_q),
    .fifo_count (fifo_count),
    .fifo_head  (fifo_head),
    .fifo_pop   (fifo_pop),
    .crc_clr    (crc_clr),
    .crc_adv    (crc_adv),
    .crc_bit    (crc_bit),
    .crc_nxt    (crc_nxt),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .busy       (busy)
  );
endmodule

// File: rtl/sft_tx_chk.sv
`timescale 1ns/1ps
module sft_tx_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          start,
  input logic          wr_en,
  input logic          ser_clk,
  input logic          ser_data,
  input logic          busy,
  input logic          wr_ovf,
  input logic [CW-1:0] fifo_count
);
  assert_line_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_data && ser_clk));

  assert_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_clk |-> ($past(bit_en) && $past(busy)));

  assert_data_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> (!ser_clk || $fell(busy)));

  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_en));

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_count == CW'(DEPTH)) |=> wr_ovf);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |=> wr_ovf);
endmodule

bind sync_frame_tx sft_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .start      (start),
  .wr_en      (wr_en),
  .ser_clk    (ser_clk),
  .ser_data   (ser_data),
  .busy       (busy),
  .wr_ovf     (wr_ovf),
  .fifo_count (fifo_count)
);

// File: tb/sync_frame_tx_tb.sv
`timescale 1ns/1ps
module sync_frame_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_sync = '0;
  logic [2:0] cfg_len = '0;
  logic       cfg_crc_en = 1'b0;
  logic       start = 1'b0;
  logic       ser_clk, ser_data, busy, wr_ovf;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;
  logic [7:0] mq[$];
  logic [7:0] cur_sync = '0;
  logic [2:0] cur_len = '0;
  logic       cur_crc = 1'b1;

  bit  cap [0:127];
  int  cap_n = 0;
  int  low_bad = 0;
  int  en_busy = 0;
  logic sclk_prev = 1'b1;
  bit  exp_b [0:127];

  always #10 clk = ~clk;

  sync_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_sync(cfg_sync), .cfg_len(cfg_len), .cfg_crc_en(cfg_crc_en),
    .start(start), .ser_clk(ser_clk), .ser_data(ser_data), .busy(busy), .wr_ovf(wr_ovf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input bit b);
    logic [15:0] r;
    r = c << 1;
    if (c[15] ^ b) r = r ^ 16'h1021;
    return r;
  endfunction

  // line monitor: captures a bit on each rising ser_clk
  always @(negedge clk) begin
    if (rst_n) begin
      if (!sclk_prev && ser_clk) begin
        if (cap_n < 128) cap[cap_n] = ser_data;
        cap_n++;
      end
      if (!sclk_prev && !ser_clk) low_bad++;
      if (bit_en && busy) en_busy++;
      sclk_prev = ser_clk;
    end
  end

  // bit enable: one-cycle pulses with at least one idle cycle between
  initial begin
    int gap;
    gap = 0;
    void'($urandom(32'd4711));
    forever begin
      @(posedge clk); #2;
      if (gap == 0) begin
        bit_en = 1'b1;
        gap = 1 + int'($urandom % 4);
      end else begin
        bit_en = 1'b0;
        gap--;
      end
    end
  end

  task automatic push(input logic [7:0] b);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_data = b;
    @(posedge clk); #2;
    wr_en = 1'b0;
    if (mq.size() < 8) mq.push_back(b);
  endtask

  task automatic set_cfg(input logic [7:0] s, input logic [2:0] l, input logic c);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sync = s; cfg_len = l; cfg_crc_en = c;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    cur_sync = s; cur_len = l; cur_crc = c;
  endtask

  task automatic pulse_start();
    @(posedge clk); #2; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
  endtask

  // sends one frame; optionally rewrites the config while it runs (R10)
  task automatic do_frame(input bit mid_change, input logic [7:0] ns, input logic [2:0] nl, input logic nc);
    int nexp, ndata, bad_d, bad_c, t;
    logic [15:0] c;
    logic [7:0] b;
    nexp = 0;
    for (int i = 7; i >= 0; i--) begin exp_b[nexp] = cur_sync[i]; nexp++; end
    c = 16'hFFFF;
    for (int k = 0; k <= int'(cur_len); k++) begin
      b = mq.pop_front();
      for (int i = 7; i >= 0; i--) begin
        exp_b[nexp] = b[i]; nexp++;
        c = ref_crc(c, b[i]);
      end
    end
    ndata = nexp;
    if (cur_crc) for (int i = 15; i >= 0; i--) begin exp_b[nexp] = c[i]; nexp++; end
    cap_n = 0; low_bad = 0; en_busy = 0;
    pulse_start();
    @(negedge clk);
    chk(busy == 1'b1, "R6 busy after start", busy, 1);
    if (mid_change) set_cfg(ns, nl, nc);
    t = 0;
    while (busy && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(cap_n == nexp, cur_crc ? "R3 frame bit count" : "R4 frame bit count", cap_n, nexp);
    bad_d = 0; bad_c = 0;
    for (int i = 0; i < nexp && i < cap_n; i++) begin
      if (cap[i] != exp_b[i]) begin
        if (i < ndata) bad_d++; else bad_c++;
      end
    end
    chk(bad_d == 0, "R2 sync/data bit mismatches", bad_d, 0);
    if (cur_crc) chk(bad_c == 0, "R3 crc bit mismatches", bad_c, 0);
    chk(en_busy == nexp + 1, "R6 bit_en pulses while busy", en_busy, nexp + 1);
    chk(low_bad == 0, "R5 ser_clk low longer than one cycle", low_bad, 0);
    chk(ser_data && ser_clk && !busy, "R1 idle line after frame", {ser_data, ser_clk, busy}, 3'b110);
    if (mid_change) begin cur_sync = ns; cur_len = nl; cur_crc = nc; end
  endtask

  initial begin
    int k, l;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({ser_data, ser_clk, busy, wr_ovf} == 4'b1100, "R1 reset state",
        {ser_data, ser_clk, busy, wr_ovf}, 4'b1100);

    // R7: empty buffer, start ignored
    set_cfg(8'h5A, 3'd0, 1'b1);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(!busy && ser_data && ser_clk, "R7 start on empty buffer ignored", busy, 0);

    // R2 R3: two bytes with CRC
    push(8'h12); push(8'h34);
    set_cfg(8'hA5, 3'd1, 1'b1);
    do_frame(0, 8'h00, 3'd0, 1'b0);

    // R4: no CRC trailer
    push(8'hC3);
    set_cfg(8'h7E, 3'd0, 1'b0);
    do_frame(0, 8'h00, 3'd0, 1'b0);

    // R7: not enough bytes for configured length
    push(8'h01); push(8'h02);
    set_cfg(8'h7E, 3'd3, 1'b1);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(!busy, "R7 start with short buffer ignored", busy, 0);
    // R8: block of bytes for two frames
    push(8'h03); push(8'h04); push(8'h05); push(8'h06); push(8'h07); push(8'h08);
    do_frame(0, 8'h00, 3'd0, 1'b0);
    do_frame(0, 8'h00, 3'd0, 1'b0);

    // R9: ninth write dropped, flag sticky
    for (int i = 0; i < 9; i++) push(8'h90 + 8'(i));
    @(negedge clk);
    chk(wr_ovf == 1'b1, "R9 overflow flag set", wr_ovf, 1);
    set_cfg(8'hE1, 3'd7, 1'b1);
    do_frame(0, 8'h00, 3'd0, 1'b0);
    chk(wr_ovf == 1'b1, "R9 overflow flag sticky", wr_ovf, 1);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(!busy && ser_data, "R7 dropped byte not sent, buffer empty", busy, 0);

    // R10: config rewritten mid-frame
    push(8'hDE); push(8'hAD); push(8'hBE); push(8'hEF);
    set_cfg(8'h3C, 3'd1, 1'b1);
    do_frame(1, 8'hC3, 3'd0, 1'b0);
    do_frame(0, 8'h00, 3'd0, 1'b0);
    do_frame(0, 8'h00, 3'd0, 1'b0);

    // random frames
    for (int it = 0; it < 20; it++) begin
      l = int'($urandom % 8);
      set_cfg(8'($urandom), 3'(l), 1'($urandom));
      k = l + 1 + int'($urandom % 3);
      while (mq.size() < k && mq.size() < 8) push(8'($urandom));
      do_frame(0, 8'h00, 3'd0, 1'b0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule